// File: doc/BRIEF.md
# Sync-Aligned Programmable Sample Delay

This block holds back each of several parallel sample streams by its own programmable number of samples. Every stream has a circular buffer. The buffer is written on every data clock cycle. It is read at the write position minus the active delay. The line therefore moves forward one sample per clock cycle, even when no real sample arrives, so that streams on different nodes keep the same shift. Each incoming word is wider than a sample. The sample is its upper `WS` bits, and the block sign-extends it to `WOUT` bits on the way out.

Delay values are written from a management port that runs on its own clock. A new value does not touch the data path straight away. The management side holds a shadow copy of all delays. A toggle handshake moves the whole copy into the data clock domain. The transferred copy becomes active only on the sample that travels with the next sync pulse. The sync pulse goes through the same fixed two-cycle pipeline as the data. It is never delayed by the programmed amount.

Top module: `sync_sample_delay`

## Requirements
- R1: Each stream has its own delay d, with 0 <= d <= DEPTH-1. The output sample of stream s equals the input sample of stream s from d clock cycles earlier, plus a fixed two-cycle latency. The line advances every clock cycle.
- R2: With a delay of 0, a sample sampled at clock edge k appears on the output after edge k+1, with no extra latency.
- R3: A transferred delay value first applies to the output beat that carries `out_sync`. Earlier beats use the previous value.
- R4: A management write whose value exceeds DEPTH-1 sets that stream's delay to DEPTH-1.
- R5: A management write has no effect on the output until a sync pulse arrives, however many cycles pass.
- R6: The sample is bits [WIN-1:WIN-WS] of each stream's input word. It is output sign-extended to WOUT bits. The lower WIN-WS input bits are ignored.
- R7: After reset, `out_data` and `out_sync` are zero and every active delay is zero until the first sync. A delay that reaches back before the first sample written since reset yields zero.
- R8: `out_sync` equals `in_sync` delayed by exactly two data clock cycles, whatever the delays are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Data clock |
| rst | input | 1 | Synchronous data-side reset, active high |
| mg_clk | input | 1 | Management clock |
| mg_rst | input | 1 | Synchronous management-side reset, active high |
| mg_wr | input | 1 | Write strobe for one delay setting |
| mg_addr | input | SW | Stream index of the write |
| mg_wdata | input | MW | Requested delay in samples (clamped to DEPTH-1) |
| in_data | input | NSTREAM*WIN | Received words, stream s at bits [s*WIN +: WIN] |
| in_sync | input | 1 | Sync pulse that arms pending delays |
| out_data | output | NSTREAM*WOUT | Delayed, sign-extended samples, stream s at [s*WOUT +: WOUT] |
| out_sync | output | 1 | Sync pulse after the fixed pipeline latency |

## Verification
A beat driven before data edge k is due on `out_data` and `out_sync` right after edge k+1. The driver tags each expected item with that edge number. The monitor samples one nanosecond after each edge and compares only the item whose due edge has come. The moment a setting finishes crossing clock domains is not fixed. For that reason the bench always waits at least thirty data cycles after a write before it raises sync. It switches its own model delay on the exact beat that carries the sync, so R3 and R5 are checked on the cycle boundary itself.

// File: rtl/sync_sample_delay.sv
`timescale 1ns/1ps
module sync_sample_delay #(
  parameter int NSTREAM = 4,
  parameter int WIN     = 16,
  parameter int WS      = 14,
  parameter int WOUT    = 16,
  parameter int DEPTH   = 64,
  parameter int MW      = 16,
  localparam int AW     = $clog2(DEPTH),
  localparam int SW     = (NSTREAM > 1) ? $clog2(NSTREAM) : 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    mg_clk,
  input  logic                    mg_rst,
  input  logic                    mg_wr,
  input  logic [SW-1:0]           mg_addr,
  input  logic [MW-1:0]           mg_wdata,
  input  logic [NSTREAM*WIN-1:0]  in_data,
  input  logic                    in_sync,
  output logic [NSTREAM*WOUT-1:0] out_data,
  output logic                    out_sync
);
  localparam logic [AW-1:0] DMAX = AW'(DEPTH - 1);
  typedef logic [NSTREAM-1:0][AW-1:0] bank_t;

  bank_t shadow, hold, staged, act;
  logic  dirty, req_t, ack_m1, ack_m2;
  logic  req_d1, req_d2, req_d3, ack_t;

  wire busy   = req_t ^ ack_m2;
  wire launch = dirty & ~busy;
  wire [AW-1:0] wval = (mg_wdata > MW'(DEPTH - 1)) ? DMAX : mg_wdata[AW-1:0];

  always_ff @(posedge mg_clk) begin
    if (mg_rst) begin
      shadow <= '0;
      hold   <= '0;
      dirty  <= 1'b0;
      req_t  <= 1'b0;
      ack_m1 <= 1'b0;
      ack_m2 <= 1'b0;
    end else begin
      if (mg_wr && (32'(mg_addr) < NSTREAM)) shadow[mg_addr] <= wval;
      if (launch) begin
        hold  <= shadow;
        req_t <= ~req_t;
      end
      if (mg_wr)       dirty <= 1'b1;
      else if (launch) dirty <= 1'b0;
      ack_m1 <= ack_t;
      ack_m2 <= ack_m1;
    end
  end

  wire req_new = req_d2 ^ req_d3;

  logic [NSTREAM-1:0][WS-1:0] s1;
  logic                       sy1, sy2;
  logic [AW-1:0]              wp;
  logic [DEPTH-1:0]           written;

  wire bank_t eff = sy1 ? staged : act;

  always_ff @(posedge clk) begin
    if (rst) begin
      req_d1  <= 1'b0;
      req_d2  <= 1'b0;
      req_d3  <= 1'b0;
      ack_t   <= 1'b0;
      staged  <= '0;
      act     <= '0;
      s1      <= '0;
      sy1     <= 1'b0;
      sy2     <= 1'b0;
      wp      <= '0;
      written <= '0;
    end else begin
      req_d1 <= req_t;
      req_d2 <= req_d1;
      req_d3 <= req_d2;
      if (req_new) begin
        staged <= hold;
        ack_t  <= req_d2;
      end
      if (sy1) act <= staged;
      for (int s = 0; s < NSTREAM; s++) s1[s] <= in_data[s*WIN + WIN - WS +: WS];
      sy1 <= in_sync;
      sy2 <= sy1;
      wp  <= wp + 1'b1;
      written[wp] <= 1'b1;
    end
  end

  assign out_sync = sy2;

  for (genvar g = 0; g < NSTREAM; g++) begin : g_lane
    logic [WS-1:0] mem [DEPTH];
    logic [WS-1:0] rd;
    wire  [AW-1:0] raddr = wp - eff[g];

    always_ff @(posedge clk) mem[wp] <= s1[g];

    always_ff @(posedge clk) begin
      if (rst)                 rd <= '0;
      else if (eff[g] == '0)   rd <= s1[g];
      else if (written[raddr]) rd <= mem[raddr];
      else                     rd <= '0;
    end

    assign out_data[g*WOUT +: WOUT] = {{(WOUT-WS){rd[WS-1]}}, rd};
  end
endmodule

// File: rtl/sync_sample_delay_chk.sv
`timescale 1ns/1ps
module sync_sample_delay_chk #(
  parameter int NSTREAM = 4,
  parameter int WS      = 14,
  parameter int WOUT    = 16,
  parameter int DEPTH   = 64,
  localparam int AW     = $clog2(DEPTH)
) (
  input logic                         clk,
  input logic                         rst,
  input logic                         in_sync,
  input logic                         out_sync,
  input logic                         sy1,
  input logic [NSTREAM-1:0][AW-1:0]   act,
  input logic [WS-1:0]                s1_0,
  input logic [WOUT-1:0]              out0
);
  logic [1:0] warm;
  logic       seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      warm <= '0;
      seen <= 1'b0;
    end else begin
      if (warm != 2'd3) warm <= warm + 2'd1;
      if (sy1) seen <= 1'b1;
    end
  end

  AST_SYNC_TWO_CYCLES: assert property (@(posedge clk) disable iff (rst)
    (warm >= 2'd2) |-> (out_sync == $past(in_sync, 2))); // R8

  AST_DELAY_SWITCH_ON_SYNC: assert property (@(posedge clk) disable iff (rst)
    (warm != 2'd0 && act != $past(act)) |-> $past(sy1)); // R3

  AST_ZERO_DELAY_PASS: assert property (@(posedge clk) disable iff (rst)
    (act[0] == '0 && !sy1) |=> (out0 == {{(WOUT-WS){$past(s1_0[WS-1])}}, $past(s1_0)})); // R2

  AST_IDLE_UNTIL_SYNC: assert property (@(posedge clk) disable iff (rst)
    !seen |-> (act == '0)); // R7
endmodule

bind sync_sample_delay sync_sample_delay_chk #(
  .NSTREAM(NSTREAM), .WS(WS), .WOUT(WOUT), .DEPTH(DEPTH)
) chk_i (
  .clk(clk), .rst(rst), .in_sync(in_sync), .out_sync(out_sync),
  .sy1(sy1), .act(act), .s1_0(s1[0]), .out0(out_data[WOUT-1:0])
);

// File: tb/sync_sample_delay_tb_top.sv
`timescale 1ns/1ps
module sync_sample_delay_tb_top;
  localparam int NS = 4, WIN = 16, WS = 14, WOUT = 16, DEPTH = 64, MW = 16, SW = 2;
  localparam int MAXK = 4096;

  logic clk = 0, mg_clk = 0, rst = 1, mg_rst = 1, mg_wr = 0, in_sync = 0;
  logic [SW-1:0]      mg_addr = '0;
  logic [MW-1:0]      mg_wdata = '0;
  logic [NS*WIN-1:0]  in_data = '0;
  wire  [NS*WOUT-1:0] out_data;
  wire                out_sync;

  always #2.5 clk = ~clk;
  always #3.5 mg_clk = ~mg_clk;

  sync_sample_delay #(.NSTREAM(NS), .WIN(WIN), .WS(WS), .WOUT(WOUT), .DEPTH(DEPTH), .MW(MW)) dut_i (
    .clk(clk), .rst(rst), .mg_clk(mg_clk), .mg_rst(mg_rst), .mg_wr(mg_wr),
    .mg_addr(mg_addr), .mg_wdata(mg_wdata), .in_data(in_data), .in_sync(in_sync),
    .out_data(out_data), .out_sync(out_sync));

  typedef struct {
    int                 due;
    logic [NS*WOUT-1:0] data;
    logic               sync;
    string              tag;
  } item_t;

  item_t q[$];
  int    n_cmp = 0, n_bad = 0, edges = 0, k = 0;
  bit    run = 0, sync_req = 0;
  string tag = "R7";
  int    pend[NS], cur[NS];
  logic [WOUT-1:0] hist[NS][MAXK];

  function automatic logic [WIN-1:0] raw_word(int s, int kk);
    return WIN'((kk * 2749 + s * 40503 + kk * kk * 13) ^ (s << 7));
  endfunction

  function automatic logic [WOUT-1:0] sext(logic [WIN-1:0] w);
    return {{(WOUT-WS){w[WIN-1]}}, w[WIN-1 -: WS]};
  endfunction

  task automatic check(string t, logic [NS*WOUT-1:0] got, logic [NS*WOUT-1:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s at edge %0d: actual %h expected %h", t, edges, got, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  // driver: one beat per negedge, expected result pushed with its due edge
  always @(negedge clk) begin
    if (run && !rst) begin
      automatic item_t it;
      automatic bit sy = sync_req;
      sync_req = 0;
      if (sy) for (int s = 0; s < NS; s++) cur[s] = pend[s];
      for (int s = 0; s < NS; s++) begin
        automatic logic [WIN-1:0] w = raw_word(s, k);
        automatic int src = k - cur[s];
        in_data[s*WIN +: WIN] = w;
        hist[s][k] = sext(w);
        it.data[s*WOUT +: WOUT] = (src < 0) ? '0 : hist[s][src];
      end
      in_sync = sy;
      it.due  = edges + 2;
      it.sync = sy;
      it.tag  = tag;
      q.push_back(it);
      k++;
    end
  end

  // monitor: sample 1 ns after each edge, compare items that fall due
  always @(posedge clk) begin
    #1;
    if (!rst) begin
      edges++;
      while (q.size() > 0 && q[0].due <= edges) begin
        automatic item_t it = q.pop_front();
        check(it.tag, out_data, it.data);
        n_cmp++;
        if (out_sync !== it.sync) begin
          n_bad++;
          $display("FAIL R8 at edge %0d: actual sync %b expected %b", edges, out_sync, it.sync);
        end
      end
    end
  end

  task automatic mg_write(int s, int v);
    @(negedge mg_clk);
    mg_wr = 1; mg_addr = SW'(s); mg_wdata = MW'(v);
    @(negedge mg_clk);
    mg_wr = 0;
    pend[s] = (v > DEPTH - 1) ? DEPTH - 1 : v;
  endtask

  task automatic cycles(int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic fire_sync();
    @(posedge clk);
    sync_req = 1;
    @(posedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    for (int s = 0; s < NS; s++) begin pend[s] = 0; cur[s] = 0; end
    cycles(3);
    @(negedge mg_clk); mg_rst = 0;
    // R7: outputs are zero while reset holds
    @(posedge clk); #1;
    check("R7", out_data, '0);
    n_cmp++;
    if (out_sync !== 1'b0) begin n_bad++; $display("FAIL R7 reset sync: actual %b expected 0", out_sync); end
    // settings written while data side sits in reset
    mg_write(0, 5); mg_write(1, 0); mg_write(2, 17); mg_write(3, 63);
    @(posedge clk); #2;
    rst = 0; run = 1;
    tag = "R7"; cycles(30);        // active delays still zero
    fire_sync();
    tag = "R7"; cycles(40);        // long delays reach before reset: zero
    tag = "R1"; cycles(80);
    tag = "R6"; cycles(20);
    mg_write(0, 0); mg_write(1, 40); mg_write(2, 3); mg_write(3, 1000);
    tag = "R5"; cycles(60);        // written but not yet armed
    tag = "R3"; fire_sync(); cycles(8);
    tag = "R2"; cycles(20);        // stream 0 at zero delay
    tag = "R4"; cycles(80);        // stream 3 clamped to DEPTH-1
    tag = "R8";
    for (int i = 0; i < 3; i++) begin fire_sync(); cycles(25); end
    run = 0;
    cycles(6);
    summary();
    $finish;
  end
endmodule